// File: doc/BRIEF.md
# Bridge Configuration Status Register

This block is the 16-bit status word of a PCI-compatible configuration header for a non-transparent bridge function. The transaction layer reports events to it as single-cycle pulses: a poisoned write request or a poisoned completion was received, a completion came back with Completer Abort or Unsupported Request status, or an ERR_FATAL/ERR_NONFATAL message was sent. The block records each event in a sticky flag. Software clears a flag by writing a 1 to it. Two command-register enables, parity response and system-error reporting, gate some of the flags.

The remaining fields are fixed. One bit shows the function's own legacy interrupt level, and one constant bit says that a capability list exists. The other fields are zero. The configuration port uses the byte address of the register. The read is combinational. A write needs an address match, a write strobe and one byte enable per byte lane. Reset is synchronous and active low.

Top module: `bridge_status_reg`

## Requirements
- R1: After reset, a read at byte offset 0x006 returns 0x0010 when the interrupt input is low.
- R2: Bit 3 of the read value follows the function's own pending-interrupt input in the same cycle.
- R3: Bits 2:0, 5, 6, 7, 10:9 and 11 always read 0 and bit 4 always reads 1. Writes do not change them.
- R4: Bit 8 sets one cycle after a poisoned write request or poisoned completion pulse, but only when the parity-response enable is 1.
- R5: Bit 15 sets one cycle after any poisoned write request or poisoned completion pulse, whatever the parity-response enable is.
- R6: Bit 12 sets one cycle after a Completer Abort completion pulse.
- R7: Bit 13 sets one cycle after an Unsupported Request completion pulse.
- R8: Bit 14 sets one cycle after an error-message-sent pulse, but only when the system-error enable is 1.
- R9: A write at offset 0x006 clears each sticky bit (8, 12–15) that has a 1 in the write data, provided the byte enable for that bit's lane is set (enable bit 0 covers bits 7:0, enable bit 1 covers bits 15:8). Data bits of 0, disabled lanes and writes at other offsets leave the bits unchanged.
- R10: When a set event and a clear of the same bit happen in the same cycle, the bit is 1 afterwards.
- R11: A read that is not at offset 0x006, or with the read strobe low, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgAddr | input | ADDR_W | Configuration byte address |
| cfgRdEn | input | 1 | Read strobe |
| cfgRdData | output | 16 | Read data, combinational |
| cfgWrEn | input | 1 | Write strobe |
| cfgByteEn | input | 2 | Byte-lane enables for a write |
| cfgWrData | input | 16 | Write data, 1 clears a sticky bit |
| evPoisonWrReq | input | 1 | Poisoned write request received |
| evPoisonCpl | input | 1 | Poisoned completion received |
| evCplAbort | input | 1 | Completion with Completer Abort status received |
| evCplUnsupp | input | 1 | Completion with Unsupported Request status received |
| evErrMsgSent | input | 1 | ERR_FATAL or ERR_NONFATAL message sent |
| intPending | input | 1 | Function's own legacy interrupt pending |
| cmdParityRespEn | input | 1 | Parity-response enable from the command register |
| cmdSysErrEn | input | 1 | System-error enable from the command register |

## Verification
The critical overlap is a set event and a software clear hitting the same sticky bit in the same clock cycle. The bench provokes it directly with an abort completion and a clear of bit 12 in one cycle, and then expects bit 12 to read 1. After that it drives random mixes of events, enables and write-1-to-clear data for many cycles. A behavioural model resolves each overlap in favour of the set. The read value is compared with the model in every cycle, so a design that lets the clear win shows a mismatch in the cycle that follows.

// File: rtl/bridge_status_pkg.sv
package bridge_status_pkg;
  localparam int STATUS_W = 16;
  localparam int LANES    = STATUS_W / 8;

  localparam int BIT_INT  = 3;
  localparam int BIT_CAP  = 4;
  localparam int BIT_MDPE = 8;
  localparam int BIT_RTA  = 12;
  localparam int BIT_RMA  = 13;
  localparam int BIT_SSE  = 14;
  localparam int BIT_DPE  = 15;

  localparam logic [STATUS_W-1:0] STICKY_MASK =
    (STATUS_W'(1) << BIT_MDPE) | (STATUS_W'(1) << BIT_RTA) |
    (STATUS_W'(1) << BIT_RMA)  | (STATUS_W'(1) << BIT_SSE) |
    (STATUS_W'(1) << BIT_DPE);

  typedef struct packed {
    logic                setMasterPar;
    logic                setDetPar;
    logic                setTgtAbort;
    logic                setMstAbort;
    logic                setSysErr;
    logic [STATUS_W-1:0] clrMask;
  } statusStrobes_t;
endpackage

// File: rtl/bridge_status_ctrl.sv
module bridge_status_ctrl
  import bridge_status_pkg::*;
#(
  parameter int                ADDR_W        = 12,
  parameter logic [ADDR_W-1:0] STATUS_OFFSET = 12'h006
) (
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic                cfgWrEn,
  input  logic [LANES-1:0]    cfgByteEn,
  input  logic [STATUS_W-1:0] cfgWrData,
  input  logic                evPoisonWrReq,
  input  logic                evPoisonCpl,
  input  logic                evCplAbort,
  input  logic                evCplUnsupp,
  input  logic                evErrMsgSent,
  input  logic                cmdParityRespEn,
  input  logic                cmdSysErrEn,
  output statusStrobes_t      strobes
);
  logic [STATUS_W-1:0] laneMask;
  logic                wrHit;
  logic                anyPoison;

  genvar lane;
  generate
    for (lane = 0; lane < LANES; lane++) begin : g_lane
      assign laneMask[lane*8 +: 8] = {8{cfgByteEn[lane]}};
    end
  endgenerate

  assign wrHit     = cfgWrEn && (cfgAddr == STATUS_OFFSET);
  assign anyPoison = evPoisonWrReq || evPoisonCpl;

  always_comb begin
    strobes              = '0;
    strobes.setDetPar    = anyPoison;
    strobes.setMasterPar = anyPoison && cmdParityRespEn;
    strobes.setTgtAbort  = evCplAbort;
    strobes.setMstAbort  = evCplUnsupp;
    strobes.setSysErr    = evErrMsgSent && cmdSysErrEn;
    strobes.clrMask      = wrHit ? (cfgWrData & laneMask & STICKY_MASK) : '0;
  end
endmodule

// File: rtl/bridge_status_dp.sv
module bridge_status_dp
  import bridge_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  statusStrobes_t      strobes,
  input  logic                intPending,
  output logic [STATUS_W-1:0] statusWord
);
  logic [STATUS_W-1:0] stickyQ;
  logic [STATUS_W-1:0] setVec;
  logic                anySet;

  always_comb begin
    setVec           = '0;
    setVec[BIT_MDPE] = strobes.setMasterPar;
    setVec[BIT_DPE]  = strobes.setDetPar;
    setVec[BIT_RTA]  = strobes.setTgtAbort;
    setVec[BIT_RMA]  = strobes.setMstAbort;
    setVec[BIT_SSE]  = strobes.setSysErr;
  end

  assign anySet = |setVec;

  always_ff @(posedge clk) begin
    if (!rstN) stickyQ <= '0;
    else       stickyQ <= ((stickyQ & ~strobes.clrMask) | setVec) & STICKY_MASK;
  end

  always_comb begin
    statusWord          = stickyQ;
    statusWord[BIT_CAP] = 1'b1;
    statusWord[BIT_INT] = intPending;
  end

  // R10: a set beats a concurrent clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setTgtAbort |=> statusWord[BIT_RTA]);
  // R5: detected parity flag sets after its strobe
  assert_detpar_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setDetPar |=> statusWord[BIT_DPE]);
  // R9: clear without set drops the bit
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrMask[BIT_RMA] && !strobes.setMstAbort) |=> !statusWord[BIT_RMA]);
  // R9: no strobe keeps sticky bits stable
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrMask == '0 && !anySet) |=> $stable(statusWord & STICKY_MASK));
endmodule

// File: rtl/bridge_status_reg.sv
module bridge_status_reg
  import bridge_status_pkg::*;
#(
  parameter int                ADDR_W        = 12,
  parameter logic [ADDR_W-1:0] STATUS_OFFSET = 12'h006
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic                cfgRdEn,
  output logic [15:0]         cfgRdData,
  input  logic                cfgWrEn,
  input  logic [1:0]          cfgByteEn,
  input  logic [15:0]         cfgWrData,
  input  logic                evPoisonWrReq,
  input  logic                evPoisonCpl,
  input  logic                evCplAbort,
  input  logic                evCplUnsupp,
  input  logic                evErrMsgSent,
  input  logic                intPending,
  input  logic                cmdParityRespEn,
  input  logic                cmdSysErrEn
);
  statusStrobes_t      strobes;
  logic [STATUS_W-1:0] statusWord;

  bridge_status_ctrl #(.ADDR_W(ADDR_W), .STATUS_OFFSET(STATUS_OFFSET)) u_ctrl (
    .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .evPoisonWrReq(evPoisonWrReq),
    .evPoisonCpl(evPoisonCpl), .evCplAbort(evCplAbort),
    .evCplUnsupp(evCplUnsupp), .evErrMsgSent(evErrMsgSent),
    .cmdParityRespEn(cmdParityRespEn), .cmdSysErrEn(cmdSysErrEn),
    .strobes(strobes)
  );

  bridge_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .intPending(intPending), .statusWord(statusWord)
  );

  assign cfgRdData = (cfgRdEn && cfgAddr == STATUS_OFFSET) ? statusWord : '0;

  // R4: master parity flag only rises after a gated poison event
  assert_mdpe_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[BIT_MDPE]) |->
      $past(cmdParityRespEn && (evPoisonWrReq || evPoisonCpl)));
  // R8: system error flag only rises after a gated message event
  assert_sse_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[BIT_SSE]) |-> $past(cmdSysErrEn && evErrMsgSent));
endmodule

// File: tb/bridge_status_reg_tb.sv
module bridge_status_reg_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] cfgAddr;
  logic        cfgRdEn, cfgWrEn;
  logic [1:0]  cfgByteEn;
  logic [15:0] cfgWrData, cfgRdData;
  logic evPoisonWrReq, evPoisonCpl, evCplAbort, evCplUnsupp, evErrMsgSent;
  logic intPending, cmdParityRespEn, cmdSysErrEn;

  int checks = 0;
  int errors = 0;
  logic [15:0] model;

  always #4 clk = ~clk;

  bridge_status_reg u_dut (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgRdEn(cfgRdEn),
    .cfgRdData(cfgRdData), .cfgWrEn(cfgWrEn), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .evPoisonWrReq(evPoisonWrReq),
    .evPoisonCpl(evPoisonCpl), .evCplAbort(evCplAbort),
    .evCplUnsupp(evCplUnsupp), .evErrMsgSent(evErrMsgSent),
    .intPending(intPending), .cmdParityRespEn(cmdParityRespEn),
    .cmdSysErrEn(cmdSysErrEn)
  );

  function automatic logic [15:0] expRead();
    if (!cfgRdEn || cfgAddr != 12'h006) return 16'h0;
    return model | 16'h0010 | (intPending ? 16'h0008 : 16'h0);
  endfunction

  task automatic idle();
    cfgAddr = 12'h006; cfgRdEn = 1'b1; cfgWrEn = 1'b0; cfgByteEn = 2'b00;
    cfgWrData = 16'h0; evPoisonWrReq = 0; evPoisonCpl = 0; evCplAbort = 0;
    evCplUnsupp = 0; evErrMsgSent = 0;
  endtask

  // Check the current read, advance the model across one clock edge
  task automatic step(input string tag);
    logic [15:0] exp, clr, setv, lanes;
    #1;
    exp = expRead();
    checks++;
    if (cfgRdData !== exp) begin
      errors++;
      $display("FAIL %s: read 0x%04h expected 0x%04h", tag, cfgRdData, exp);
    end
    lanes = {{8{cfgByteEn[1]}}, {8{cfgByteEn[0]}}};
    clr  = (rstN && cfgWrEn && cfgAddr == 12'h006) ? (cfgWrData & lanes) : 16'h0;
    setv = 16'h0;
    if (evPoisonWrReq || evPoisonCpl) begin
      setv[15] = 1'b1;
      if (cmdParityRespEn) setv[8] = 1'b1;
    end
    if (evCplAbort)  setv[12] = 1'b1;
    if (evCplUnsupp) setv[13] = 1'b1;
    if (evErrMsgSent && cmdSysErrEn) setv[14] = 1'b1;
    @(posedge clk);
    if (!rstN) model = 16'h0;
    else model = ((model & ~clr) | setv) & 16'hF100;
    @(negedge clk);
    idle();
  endtask

  task automatic clearAll();
    cfgWrEn = 1; cfgByteEn = 2'b11; cfgWrData = 16'hFFFF; step("R9");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model = 16'h0; rstN = 1'b0; intPending = 0; cmdParityRespEn = 0; cmdSysErrEn = 0;
    idle();
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    step("R1");                                  // reset value 0x0010
    intPending = 1; step("R2"); intPending = 0; step("R2");
    cfgWrEn = 1; cfgByteEn = 2'b11; cfgWrData = 16'hFFFF; step("R3");
    step("R3");                                  // fixed bits unchanged
    evPoisonWrReq = 1; step("R4"); step("R5");  // parity enable off: only bit 15
    clearAll(); step("R9");
    cmdParityRespEn = 1; evPoisonCpl = 1; step("R4"); step("R4");
    clearAll();
    evCplAbort = 1; step("R6"); step("R6");
    evCplUnsupp = 1; step("R7"); step("R7");
    evErrMsgSent = 1; step("R8"); step("R8");   // system error enable off
    cmdSysErrEn = 1; evErrMsgSent = 1; step("R8"); step("R8");
    cfgWrEn = 1; cfgByteEn = 2'b11; cfgWrData = 16'h0000; step("R9"); step("R9");
    cfgWrEn = 1; cfgByteEn = 2'b01; cfgWrData = 16'hFFFF; step("R9"); step("R9");
    cfgWrEn = 1; cfgByteEn = 2'b10; cfgWrData = 16'h1000; step("R9"); step("R9");
    cfgWrEn = 1; cfgByteEn = 2'b11; cfgWrData = 16'hFFFF; cfgAddr = 12'h004; step("R11");
    step("R9");                                  // off-offset write ignored
    cfgRdEn = 0; step("R11");
    evCplAbort = 1; cfgWrEn = 1; cfgByteEn = 2'b10; cfgWrData = 16'h1000; step("R10");
    step("R10");                                 // bit 12 still set
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      evPoisonWrReq = r[0]; evPoisonCpl = r[1]; evCplAbort = r[2];
      evCplUnsupp = r[3]; evErrMsgSent = r[4]; cmdParityRespEn = r[5];
      cmdSysErrEn = r[6]; intPending = r[7]; cfgWrEn = r[8];
      cfgByteEn = r[10:9]; cfgWrData = r[26:11];
      cfgAddr = r[27] ? 12'h002 : 12'h006; cfgRdEn = ~r[28];
      step("R10");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule